// File: doc/BRIEF.md
# Cross-Product FM Discriminator

This block turns a stream of complex baseband samples into a real signal that is proportional to the instantaneous frequency of the input. It keeps the last three accepted IQ samples. For each new sample it forms a central difference of I and of Q over two sample steps. It multiplies each difference by the opposite component of the middle sample. The two products are rescaled by 15 fractional bits and subtracted, and the result is clamped to 16 bits. There is no arctangent, no magnitude normalisation and no gain stage after the cross-product.

The stream is free-flowing: there is no ready or backpressure. A valid strobe marks each sample, and samples typically arrive far more slowly than the clock. The arithmetic is split over a short fixed pipeline so that it closes at 125 MHz. The output strobe is the input strobe delayed by exactly that pipeline depth.

Top module: `fm_discriminator`

## Requirements
- R1: During and after a synchronous active-high reset, `dmod_valid` is 0 and `dmod_data` is 0 until the first result.
- R2: The history (current, one back, two back) advances only when `iq_valid` is 1. Values on `iq_i`/`iq_q` while `iq_valid` is 0 have no effect on any later result.
- R3: For accepted samples x[n], the result is floor(I[n-1]*(Q[n]-Q[n-2]) / 2^15) - floor(Q[n-1]*(I[n]-I[n-2]) / 2^15). Each product is arithmetic-shifted right by 15 before the subtraction.
- R4: `dmod_valid` is 1 exactly 4 clock cycles after each cycle in which `iq_valid` is 1, for one cycle per input, and at no other time.
- R5: A result above 32767 is output as 32767, and a result below -32768 is output as -32768. It never wraps.
- R6: `dmod_data` holds its last value in every cycle where `dmod_valid` is 0.
- R7: A constant-amplitude tone whose phase advances by a fixed step gives a constant output. The output is positive when Q leads I (counter-clockwise rotation) and negative for the opposite direction.
- R8: After reset the history is all zeros, so the first two results are computed with zero for the samples that are missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_valid | input | 1 | Input sample strobe |
| iq_i | input | 16 | In-phase sample, signed |
| iq_q | input | 16 | Quadrature sample, signed |
| dmod_valid | output | 1 | Result strobe |
| dmod_data | output | 16 | Demodulated sample, signed, saturated |

## Verification
The bench holds a model of the accepted-sample history and drives random samples with random gaps. During the gaps it puts junk on the data inputs. A design that shifted its history on every clock, or latched data without the strobe, would give results that do not match the model. Directed full-scale samples drive the difference-product sum past both 16-bit limits. A wrapping design would show the wrong sign there, and shifting after the subtraction instead of before would give off-by-one values on negative products. Rotating tones in both directions check that the output is constant and has the right sign. An ordering fault in the delay line, where current is copied straight into two back, would break both the random results and the tone results.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  // Default sample width and number of fractional bits in the products.
  parameter int unsigned FMD_SAMPLE_W = 16;
  parameter int unsigned FMD_FRAC_W   = 15;
  // Register stages from input to output.
  parameter int unsigned FMD_LATENCY  = 4;
endpackage

// File: rtl/fmd_history.sv
module fmd_history #(
  parameter int unsigned W = fmd_pkg::FMD_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                hv,
  output logic signed [W-1:0] cur_i,
  output logic signed [W-1:0] cur_q,
  output logic signed [W-1:0] one_i,
  output logic signed [W-1:0] one_q,
  output logic signed [W-1:0] two_i,
  output logic signed [W-1:0] two_q
);
  // Every stage takes the previous stage's old value on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      hv    <= 1'b0;
      cur_i <= '0; cur_q <= '0;
      one_i <= '0; one_q <= '0;
      two_i <= '0; two_q <= '0;
    end else begin
      hv <= in_valid;
      if (in_valid) begin
        two_i <= one_i; two_q <= one_q;
        one_i <= cur_i; one_q <= cur_q;
        cur_i <= in_i;  cur_q <= in_q;
      end
    end
  end

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(one_i) && $stable(one_q) && $stable(two_i) && $stable(two_q)));
  // R2
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (two_i == $past(one_i) && one_q == $past(cur_q)));
endmodule

// File: rtl/fmd_xprod.sv
module fmd_xprod #(
  parameter int unsigned W = fmd_pkg::FMD_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hv,
  input  logic signed [W-1:0] cur_i,
  input  logic signed [W-1:0] cur_q,
  input  logic signed [W-1:0] one_i,
  input  logic signed [W-1:0] one_q,
  input  logic signed [W-1:0] two_i,
  input  logic signed [W-1:0] two_q,
  output logic                pv,
  output logic signed [2*W:0] prod_a,
  output logic signed [2*W:0] prod_b
);
  localparam int unsigned DW = W + 1;
  localparam int unsigned PW = 2 * W + 1;

  logic signed [DW-1:0] d_i, d_q;
  logic signed [W-1:0]  m_i, m_q;
  logic                 dv;
  logic signed [PW-1:0] ext_mi, ext_mq, ext_di, ext_dq;

  // Stage 1: two-step differences, each one bit wider than a sample
  always_ff @(posedge clk) begin
    if (rst) begin
      dv <= 1'b0;
      d_i <= '0; d_q <= '0; m_i <= '0; m_q <= '0;
    end else begin
      dv <= hv;
      if (hv) begin
        d_i <= {cur_i[W-1], cur_i} - {two_i[W-1], two_i};
        d_q <= {cur_q[W-1], cur_q} - {two_q[W-1], two_q};
        m_i <= one_i;
        m_q <= one_q;
      end
    end
  end

  always_comb begin
    ext_mi = {{(PW-W){m_i[W-1]}}, m_i};
    ext_mq = {{(PW-W){m_q[W-1]}}, m_q};
    ext_di = {{(PW-DW){d_i[DW-1]}}, d_i};
    ext_dq = {{(PW-DW){d_q[DW-1]}}, d_q};
  end

  // Stage 2: the two cross products
  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= 1'b0;
      prod_a <= '0; prod_b <= '0;
    end else begin
      pv <= dv;
      if (dv) begin
        prod_a <= ext_mi * ext_dq;
        prod_b <= ext_mq * ext_di;
      end
    end
  end

  // R4
  xprod_step_chk: assert property (@(posedge clk) disable iff (rst) pv |-> $past(hv, 2));
  // R3
  xprod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dv |=> ($stable(prod_a) && $stable(prod_b)));
endmodule

// File: rtl/fmd_combine.sv
module fmd_combine #(
  parameter int unsigned W    = fmd_pkg::FMD_SAMPLE_W,
  parameter int unsigned FRAC = fmd_pkg::FMD_FRAC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pv,
  input  logic signed [2*W:0] prod_a,
  input  logic signed [2*W:0] prod_b,
  output logic                ov,
  output logic signed [W-1:0] odata
);
  localparam int unsigned PW = 2 * W + 1;
  localparam int unsigned SW = PW + 1;
  localparam logic signed [SW-1:0] SAT_HI = SW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] SAT_LO = -SW'(64'sd1 <<< (W - 1));

  logic signed [PW-1:0] sh_a, sh_b;
  logic signed [SW-1:0] diff;

  always_comb begin
    sh_a = prod_a >>> FRAC;
    sh_b = prod_b >>> FRAC;
    diff = {sh_a[PW-1], sh_a} - {sh_b[PW-1], sh_b};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov    <= 1'b0;
      odata <= '0;
    end else begin
      ov <= pv;
      if (pv) begin
        if (diff > SAT_HI)      odata <= SAT_HI[W-1:0];
        else if (diff < SAT_LO) odata <= SAT_LO[W-1:0];
        else                    odata <= diff[W-1:0];
      end
    end
  end

  // R5
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && diff > SAT_HI) |=> (odata == SAT_HI[W-1:0]));
  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && diff < SAT_LO) |=> (odata == SAT_LO[W-1:0]));
endmodule

// File: rtl/fm_discriminator.sv
module fm_discriminator #(
  parameter int unsigned W    = fmd_pkg::FMD_SAMPLE_W,
  parameter int unsigned FRAC = fmd_pkg::FMD_FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         iq_valid,
  input  logic [W-1:0] iq_i,
  input  logic [W-1:0] iq_q,
  output logic         dmod_valid,
  output logic [W-1:0] dmod_data
);
  logic                hv, pv;
  logic signed [W-1:0] cur_i, cur_q, one_i, one_q, two_i, two_q;
  logic signed [2*W:0] prod_a, prod_b;
  logic signed [W-1:0] odata;

  fmd_history #(.W(W)) u_hist (
    .clk(clk), .rst(rst), .in_valid(iq_valid),
    .in_i($signed(iq_i)), .in_q($signed(iq_q)),
    .hv(hv), .cur_i(cur_i), .cur_q(cur_q),
    .one_i(one_i), .one_q(one_q), .two_i(two_i), .two_q(two_q)
  );

  fmd_xprod #(.W(W)) u_xprod (
    .clk(clk), .rst(rst), .hv(hv),
    .cur_i(cur_i), .cur_q(cur_q), .one_i(one_i), .one_q(one_q),
    .two_i(two_i), .two_q(two_q),
    .pv(pv), .prod_a(prod_a), .prod_b(prod_b)
  );

  fmd_combine #(.W(W), .FRAC(FRAC)) u_comb (
    .clk(clk), .rst(rst), .pv(pv), .prod_a(prod_a), .prod_b(prod_b),
    .ov(dmod_valid), .odata(odata)
  );

  assign dmod_data = odata;

  // R4
  lat_out_chk: assert property (@(posedge clk) disable iff (rst)
    dmod_valid |-> $past(iq_valid, 4));
  // R4
  lat_in_chk: assert property (@(posedge clk) disable iff (rst)
    iq_valid |-> ##4 dmod_valid);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dmod_valid |-> $stable(dmod_data));
  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (!dmod_valid && dmod_data == '0));
endmodule

// File: tb/fm_discriminator_tb.sv
module fm_discriminator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iq_valid = 1'b0;
  logic [15:0] iq_i = '0, iq_q = '0;
  logic        dmod_valid;
  logic [15:0] dmod_data;

  int checks = 0, failures = 0, cyc = 0;
  int due_q[$], exp_q[$], tag_q[$];
  int rec[$];
  bit recording = 1'b0;
  int mh_i[3], mh_q[3];
  logic [15:0] last_out = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fm_discriminator u_dut (
    .clk(clk), .rst(rst), .iq_valid(iq_valid), .iq_i(iq_i), .iq_q(iq_q),
    .dmod_valid(dmod_valid), .dmod_data(dmod_data)
  );

  function automatic int ref_out(int i0, int q0, int i1, int q1, int i2, int q2);
    longint pa, pb, t;
    pa = longint'(i1) * longint'(q0 - q2);
    pb = longint'(q1) * longint'(i0 - i2);
    t  = (pa >>> 15) - (pb >>> 15);
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin mh_i[k] = 0; mh_q[k] = 0; end
  endtask

  // tag: 3 = R3 random, 5 = R5 saturation, 8 = R8 first after reset
  task automatic send(int si, int sq, int tag);
    @(negedge clk);
    iq_valid = 1'b1;
    iq_i = 16'(si); iq_q = 16'(sq);
    mh_i[2] = mh_i[1]; mh_q[2] = mh_q[1];
    mh_i[1] = mh_i[0]; mh_q[1] = mh_q[0];
    mh_i[0] = si;      mh_q[0] = sq;
    due_q.push_back(cyc + 4);
    exp_q.push_back(ref_out(mh_i[0], mh_q[0], mh_i[1], mh_q[1], mh_i[2], mh_q[2]));
    tag_q.push_back(tag);
  endtask

  // Idle cycles with junk data (R2)
  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      iq_valid = 1'b0;
      iq_i = 16'($urandom);
      iq_q = 16'($urandom);
    end
  endtask

  // Output checker, samples at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        int e, tg;
        e = exp_q.pop_front(); tg = tag_q.pop_front(); void'(due_q.pop_front());
        // R4: strobe exactly 4 cycles after the input
        check(dmod_valid == 1'b1, "R4", int'(dmod_valid), 1);
        if (tg == 5)      check($signed(dmod_data) == e, "R5", $signed(dmod_data), e);
        else if (tg == 8) check($signed(dmod_data) == e, "R8", $signed(dmod_data), e);
        else              check($signed(dmod_data) == e, "R3/R2", $signed(dmod_data), e);
        if (recording) rec.push_back(int'($signed(dmod_data)));
      end else begin
        check(dmod_valid == 1'b0, "R4", int'(dmod_valid), 0);
        // R6: output holds while strobe is low
        check(dmod_data == last_out, "R6", $signed(dmod_data), $signed(last_out));
      end
      last_out = dmod_data;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tone(real step, bit positive);
    int mn, mx;
    rec.delete();
    for (int k = 0; k < 48; k++) begin
      real ph;
      ph = step * k;
      recording = (k >= 6);
      send(int'(20000.0 * $cos(ph)), int'(20000.0 * $sin(ph)), 3);
      idle(1 + (k % 3));
    end
    idle(6);
    recording = 1'b0;
    mn = 1 << 30; mx = -(1 << 30);
    foreach (rec[k]) begin
      if (rec[k] < mn) mn = rec[k];
      if (rec[k] > mx) mx = rec[k];
    end
    // R7: constant within rounding, sign follows rotation
    check(mx - mn <= 4, "R7", mx - mn, 4);
    if (positive) check(mn > 500, "R7", mn, 501);
    else          check(mx < -500, "R7", mx, -501);
  endtask

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(dmod_valid == 1'b0, "R1", int'(dmod_valid), 0);
    check(dmod_data == 16'd0, "R1", $signed(dmod_data), 0);
    rst = 1'b0;
    idle(3);
    check(dmod_valid == 1'b0 && dmod_data == 16'd0, "R1", $signed(dmod_data), 0);

    // R8: first results use zero history
    send(1000, 2000, 8);
    idle(2);
    send(3000, -4000, 8);
    idle(6);

    // R2/R3/R4: random samples, random gaps (including back-to-back)
    for (int k = 0; k < 300; k++) begin
      send(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768, 3);
      idle(int'($urandom_range(0, 5)));
    end
    idle(6);

    // R5: negative clamp
    send(0, -32768, 3);
    send(-32768, 32767, 3);
    send(32767, 32767, 5);
    idle(6);
    // R5: positive clamp
    send(32767, -32768, 3);
    send(32767, 32767, 3);
    send(-32768, 32767, 5);
    idle(6);

    // R7: rotations in both directions
    tone(0.05, 1'b1);
    tone(-0.05, 1'b0);
    tone(0.2, 1'b1);

    // R1: reset in the middle clears history again
    @(negedge clk); rst = 1'b1; iq_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(dmod_valid == 1'b0 && dmod_data == 16'd0, "R1", $signed(dmod_data), 0);
    rst = 1'b0; last_out = '0;
    model_reset();
    send(-500, 700, 8);
    send(1200, 300, 8);
    send(-900, -2500, 8);
    idle(8);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule